// File: doc/BRIEF.md
# Open-String Regulation Supervisor

This block decides which LED channels feed the boost converter's minimum-voltage regulation loop. The loop drives the lowest pin voltage among the channels in the mask to 0.5 V. A string that opens pulls its channel pin to zero, so the loop runs effectively open and the output voltage climbs until the overvoltage comparator trips. On that event the supervisor removes every enabled channel whose pin is flagged near zero from the regulation mask. A removed channel is only left out of the feedback. Its current sink stays on, so it carries the programmed current again if the string reconnects.

Removed channels come back in two ways. A re-enable pulse restores all of them at once. A later overvoltage event also re-evaluates every channel: a removed channel whose near-zero flag has cleared is restored, and a channel whose flag is still set stays out. The overvoltage flag arrives asynchronously and already carries comparator hysteresis. It is synchronized here, and only its rising edge counts as an event. If an event would remove every enabled channel, the mask is kept and a fault output is raised, because an empty feedback set would leave the loop with nothing to regulate.

Top module: `open_string_supervisor`

## Requirements
- R1: After reset, no channel is removed, so `reg_mask` equals `ch_enable` and `strand_fault` is 0.
- R2: `reg_mask` is at all times `ch_enable` with the removed channels cleared, so it is never wider than `ch_enable`.
- R3: An overvoltage event is the rising edge of `ovp_raw` after a two-flop synchronizer. Its effect shows on the outputs after the third rising clock edge that samples `ovp_raw` high. Holding `ovp_raw` high produces no further event.
- R4: On an event, the removed set becomes exactly the enabled channels whose `pin_low` bit is 1.
- R5: On a later event, a removed channel whose `pin_low` bit is 0 is restored, and one whose bit is still 1 stays removed.
- R6: Between events, changes on `pin_low` have no effect on `reg_mask` or `strand_fault`.
- R7: `reenable` high at a clock edge clears every removal and `strand_fault`. It takes priority over an event at the same edge.
- R8: If an event would remove every channel of a non-zero `ch_enable`, the removed set is left unchanged and `strand_fault` goes to 1. The fault then holds until `reenable` or an event that leaves at least one channel in the mask. When `ch_enable` is zero an event raises no fault.
- R9: Clearing a channel's `ch_enable` bit drops its removal, so the channel is back in `reg_mask` when it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_enable | input | NUM_CH | Channels enabled by the string-count selection |
| pin_low | input | NUM_CH | Per-channel flag: pin voltage near zero |
| ovp_raw | input | 1 | Overvoltage comparator output (asynchronous, with hysteresis) |
| reenable | input | 1 | IC re-enable pulse |
| reg_mask | output | NUM_CH | Channels included in the minimum-voltage loop |
| strand_fault | output | 1 | An event would have emptied the mask |

## Verification
The bench aims at the exact cycle an event lands. A design with one synchronizer stage too few or too many would update the mask one cycle early or late, and a level-sensitive design would keep re-evaluating while the flag stays high. It drives `pin_low` changes between events, which a design sampling the flags continuously would act on. It also covers the partial-restore event, where a design restoring everything or nothing gets the mask wrong, and the all-channels-open event, where a naive design empties the mask instead of raising the fault. It also puts `reenable` on the same edges as an event, which exposes a wrong priority, and clears and restores enable bits to catch removals that outlive a disabled channel.

// File: rtl/osr_pkg.sv
package osr_pkg;

    // Action taken on the removal set at one clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,  // no event: keep removals of enabled channels
        ACT_CLEAR  = 2'd1,  // re-enable: drop every removal
        ACT_APPLY  = 2'd2,  // event: take the near-zero enabled channels
        ACT_REFUSE = 2'd3   // event would empty the mask: keep, flag fault
    } osr_action_e;

endpackage

// File: rtl/ovp_edge_sync.sv
module ovp_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovp_raw,
    output logic ovp_event
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], ovp_raw};
        st_d.last  = st_q.chain[SYNC_STAGES-1];
        ovp_event  = st_q.chain[SYNC_STAGES-1] & ~st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: an edge yields a single-cycle event even if the flag stays high
    assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_event |=> !ovp_event);

endmodule

// File: rtl/open_string_tracker.sv
module open_string_tracker
    import osr_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] pin_low,
    input  logic              ovp_event,
    input  logic              reenable,
    output logic [NUM_CH-1:0] removed,
    output logic              strand_fault
);

    typedef struct packed {
        logic [NUM_CH-1:0] removed;
        logic              fault;
    } trk_state_t;

    trk_state_t        st_d, st_q;
    logic [NUM_CH-1:0] cand;
    logic [NUM_CH-1:0] survivors;
    logic              would_strand;
    osr_action_e       act;

    // Per-channel candidate: enabled and showing a near-zero pin.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
        assign cand[g]      = ch_enable[g] & pin_low[g];
        assign survivors[g] = ch_enable[g] & ~pin_low[g];
    end

    assign would_strand = (|ch_enable) && !(|survivors);

    always_comb begin
        if (reenable) begin
            act = ACT_CLEAR;
        end else if (ovp_event && would_strand) begin
            act = ACT_REFUSE;
        end else if (ovp_event) begin
            act = ACT_APPLY;
        end else begin
            act = ACT_HOLD;
        end

        st_d = st_q;
        unique case (act)
            ACT_CLEAR: begin
                st_d.removed = '0;
                st_d.fault   = 1'b0;
            end
            ACT_APPLY: begin
                st_d.removed = cand;
                st_d.fault   = 1'b0;
            end
            ACT_REFUSE: begin
                st_d.removed = st_q.removed & ch_enable;
                st_d.fault   = 1'b1;
            end
            default: begin
                st_d.removed = st_q.removed & ch_enable;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign removed      = st_q.removed;
    assign strand_fault = st_q.fault;

    // R7: re-enable wipes removals and fault on the next cycle
    assert_reenable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reenable |=> (removed == '0) && !strand_fault);

    // R6: without an event no channel can newly enter the removal set
    assert_no_new_removal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovp_event && !reenable) |=> ((removed & ~$past(removed)) == '0));

    // R4: a normal event loads exactly the near-zero enabled channels
    assert_event_removes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_event && !reenable && !would_strand) |=> (removed == $past(cand)) && !strand_fault);

    // R8: an event that would empty the mask raises the fault
    assert_strand_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_event && !reenable && would_strand) |=> strand_fault);

    // R8: the fault is only raised by an event
    assert_fault_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strand_fault) |-> $past(ovp_event));

endmodule

// File: rtl/open_string_supervisor.sv
module open_string_supervisor #(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] pin_low,
    input  logic              ovp_raw,
    input  logic              reenable,
    output logic [NUM_CH-1:0] reg_mask,
    output logic              strand_fault
);

    logic              ovp_event;
    logic [NUM_CH-1:0] removed;

    ovp_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovp_raw  (ovp_raw),
        .ovp_event(ovp_event)
    );

    open_string_tracker #(
        .NUM_CH(NUM_CH)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_enable   (ch_enable),
        .pin_low     (pin_low),
        .ovp_event   (ovp_event),
        .reenable    (reenable),
        .removed     (removed),
        .strand_fault(strand_fault)
    );

    assign reg_mask = ch_enable & ~removed;

    // R2/R8: a registered fault never coexists with an empty mask for a stable non-zero enable
    assert_mask_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strand_fault && (ch_enable != '0) && $stable(ch_enable) && ($past(reg_mask) != '0))
            |-> (reg_mask != '0));

endmodule

// File: tb/open_string_supervisor_tb.sv
module open_string_supervisor_tb;

    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ch_enable = 8'hFF;
    logic [NCH-1:0] pin_low = 8'h00;
    logic           ovp_raw = 1'b0;
    logic           reenable = 1'b0;
    logic [NCH-1:0] reg_mask;
    logic           strand_fault;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [NCH-1:0] m_removed = '0;
    bit             m_fault   = 1'b0;
    bit             hist[$]   = '{0, 0, 0};

    always #5 clk = ~clk;

    open_string_supervisor #(.NUM_CH(NCH), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .pin_low(pin_low),
        .ovp_raw(ovp_raw), .reenable(reenable),
        .reg_mask(reg_mask), .strand_fault(strand_fault)
    );

    // Behavioural model: hist[k] is the flag seen k+1 edges ago.
    always @(posedge clk) begin
        bit             evt;
        logic [NCH-1:0] cand;
        if (!rst_n) begin
            m_removed = '0;
            m_fault   = 1'b0;
            hist      = '{0, 0, 0};
        end else begin
            evt = hist[1] && !hist[2];
            hist.push_front(ovp_raw);
            void'(hist.pop_back());
            cand = pin_low & ch_enable;
            if (reenable) begin
                m_removed = '0;
                m_fault   = 1'b0;
            end else if (evt && (ch_enable != 0) && ((ch_enable & ~cand) == 0)) begin
                m_removed = m_removed & ch_enable;
                m_fault   = 1'b1;
            end else if (evt) begin
                m_removed = cand;
                m_fault   = 1'b0;
            end else begin
                m_removed = m_removed & ch_enable;
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        logic [NCH-1:0] exp_mask;
        if (rst_n && !done) begin
            exp_mask = ch_enable & ~m_removed;
            n_tests++;
            if (reg_mask !== exp_mask || strand_fault !== m_fault) begin
                n_fail++;
                $display("FAIL %s cycle compare: mask=%h fault=%b expected mask=%h fault=%b",
                         cur_req, reg_mask, strand_fault, exp_mask, m_fault);
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string req, input logic [NCH-1:0] em, input logic ef);
        n_tests++;
        if (reg_mask !== em || strand_fault !== ef) begin
            n_fail++;
            $display("FAIL %s: mask=%h fault=%b expected mask=%h fault=%b",
                     req, reg_mask, strand_fault, em, ef);
        end
    endtask

    task automatic ovp_pulse();
        ovp_raw = 1'b1;
        tick(6);
        ovp_raw = 1'b0;
        tick(4);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset state", 8'hFF, 1'b0);

        cur_req = "R6";
        pin_low = 8'h05;
        tick(5);
        chk("R6 flags without event", 8'hFF, 1'b0);

        // R3 timing: raw high before edge 1, effect after edge 3
        cur_req = "R3";
        ovp_raw = 1'b1;
        tick(2);
        chk("R3 no effect after two edges", 8'hFF, 1'b0);
        tick(1);
        chk("R4 removal after third edge", 8'hFA, 1'b0);
        tick(5);
        chk("R3 held flag gives one event", 8'hFA, 1'b0);
        ovp_raw = 1'b0;
        tick(4);

        cur_req = "R6";
        pin_low = 8'h04;
        tick(4);
        chk("R6 recovered flag ignored until event", 8'hFA, 1'b0);

        cur_req = "R5";
        pin_low = 8'h14;
        ovp_pulse();
        chk("R5 partial restore", 8'hEB, 1'b0);

        cur_req = "R7";
        reenable = 1'b1;
        tick(1);
        reenable = 1'b0;
        tick(1);
        chk("R7 reenable restores all", 8'hFF, 1'b0);

        cur_req = "R8";
        ch_enable = 8'h0F;
        pin_low   = 8'h0F;
        ovp_pulse();
        chk("R8 all open keeps mask", 8'h0F, 1'b1);
        pin_low = 8'h07;
        tick(4);
        chk("R8 fault holds without event", 8'h0F, 1'b1);
        pin_low = 8'h03;
        ovp_pulse();
        chk("R8 fault cleared by good event", 8'h0C, 1'b0);

        cur_req = "R9";
        ch_enable = 8'h0E;
        tick(1);
        chk("R9 disabled channel leaves", 8'h0C, 1'b0);
        ch_enable = 8'h0F;
        tick(1);
        chk("R9 re-enabled channel returns", 8'h0D, 1'b0);

        cur_req = "R8";
        ch_enable = 8'h00;
        pin_low   = 8'hFF;
        ovp_pulse();
        chk("R8 empty enable raises no fault", 8'h00, 1'b0);

        cur_req = "R7";
        ch_enable = 8'hFF;
        pin_low   = 8'h30;
        ovp_raw   = 1'b1;
        reenable  = 1'b1;
        tick(6);
        reenable  = 1'b0;
        ovp_raw   = 1'b0;
        tick(4);
        chk("R7 reenable wins over event", 8'hFF, 1'b0);

        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            ch_enable = 8'($urandom);
            pin_low   = 8'($urandom) & 8'($urandom);
            if (($urandom % 6) == 0) ovp_raw = ~ovp_raw;
            reenable = (($urandom % 40) == 0);
            tick(1);
        end
        reenable = 1'b0;
        tick(2);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

endmodule